// File: doc/BRIEF.md
# Bi-Endian Load/Store Lane Adapter

This block connects a processor's load/store pipeline to a little-endian memory bus whose data path is one word wide. Each request carries an address, an access size, store data and a signed-load flag. The adapter turns it into a bus beat: the final address, per-lane byte enables and store data placed in the right lanes. When the memory response comes back, it extracts the load result, reorders it and extends it to a full word.

Three data orderings are available. In little-endian order, bytes go straight through. In byte-invariant big-endian order, bytes keep their addresses but multi-byte values are reversed. In word-invariant big-endian order, full words are unchanged but sub-word accesses are mirrored to the opposite end of the word. A default ordering is chosen either by a locked hardware strap or by a software-written configuration value. A single access can select a different ordering for itself alone. Accesses whose alignment the active ordering does not accept are reported as faults and never reach the bus.

Top module: `endianLaneAdapter`

## Requirements
- R1: The default ordering is `strapMode` when `strapLock` is 1, otherwise `cfgMode`. When `reqOvrValid` is 1, `reqOvrMode` applies to that request only. Mode codes: 00 little-endian, 01 byte-invariant big-endian, 10 word-invariant big-endian, 11 behaves as little-endian.
- R2: Size codes: 00 byte, 01 halfword, 10 word, 11 behaves as word. `busBe` sets exactly 1, 2 or 4 consecutive bits, starting at the lane given by the low two bits of `busAddr`.
- R3: In word-invariant order, the low address bits are XORed with 3 for a byte and with 2 for a halfword. A word keeps its address. Data bytes are never reordered in this mode.
- R4: In word-invariant order, a halfword at an odd offset or a word at a non-zero offset faults, whatever the value of `unalignEn`.
- R5: In the other two orders, a halfword at offset 1 or 3 and a word at a non-zero offset fault when `unalignEn` is 0. When `unalignEn` is 1, such an access is issued only if all of its bytes fit inside the addressed word; otherwise it still faults.
- R6: In byte-invariant order, halfword and word values are byte-reversed for both stores and loads. Bytes pass through unchanged. The address is never modified in this mode.
- R7: Store byte k of the (possibly reversed) value appears on bus lane offset+k. Lanes that are not enabled carry zero.
- R8: Load data is taken from the enabled lanes, reordered as the mode requires and moved down to bit 0. If `reqSigned` was 1 on the request it is sign-extended to 32 bits, otherwise zero-extended.
- R9: A request accepted on a clock edge shows up on `busValid`, `busWrite`, `busAddr`, `busBe` and `busWdata` for exactly the following cycle. A faulting request instead raises `fault` for that one cycle and produces no bus beat.
- R10: `loadValid` and `loadData` appear in the cycle after `rspValid` is sampled high. They use the context of the most recently issued load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapLock | input | 1 | Selects the strap as the default mode source |
| strapMode | input | 2 | Mode code from the hardware strap |
| cfgMode | input | 2 | Mode code from the configuration register |
| unalignEn | input | 1 | Permits in-word unaligned access in little-endian and byte-invariant orders |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqSize | input | 2 | Access size code |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Store value, right-aligned |
| reqSigned | input | 1 | Sign-extend the load result |
| reqOvrValid | input | 1 | Use the per-access mode |
| reqOvrMode | input | 2 | Per-access mode code |
| rspValid | input | 1 | Memory read data valid |
| rspRdata | input | DATA_W | Memory read data, little-endian lanes |
| busValid | output | 1 | Bus beat valid |
| busWrite | output | 1 | Bus beat is a store |
| busAddr | output | ADDR_W | Final byte address |
| busBe | output | DATA_W/8 | Lane enables |
| busWdata | output | DATA_W | Store lanes |
| fault | output | 1 | Misalignment fault pulse |
| loadValid | output | 1 | Load result valid |
| loadData | output | DATA_W | Extended load result |

## Verification
On every cycle, the assertions check four things: a fault and a bus beat never occur together; each beat or fault follows a request one cycle earlier; the enable count is legal; and load results track responses by one cycle. They also check the word-invariant byte mirroring, the unchanged byte-invariant address, and the word-invariant odd-offset fault when the mode is chosen per access. Only the bench scenarios can show the lane-by-lane placement of store data, the reordering and extension of load results, and the choice of default source between strap and register. The same goes for the unaligned-enable boundary at the word edge.

// File: rtl/elaPkg.sv
package elaPkg;

  localparam int LANE_IDX_W = 4;

  typedef enum logic [1:0] {
    MODE_LE  = 2'd0,
    MODE_BI  = 2'd1,
    MODE_WI  = 2'd2,
    MODE_RSV = 2'd3
  } endMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic                  capture;
    logic                  capSwap;
    accSize_e              capSize;
    logic [LANE_IDX_W-1:0] capOffs;
    logic                  ldTake;
    logic                  ldSwap;
    accSize_e              ldSize;
    logic [LANE_IDX_W-1:0] ldOffs;
    logic                  ldSigned;
  } ctrlStrobes_t;

  function automatic int sizeBytes(accSize_e s, int lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/elaCtrl.sv
module elaCtrl
  import elaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           strapLock,
  input  logic [1:0]                     strapMode,
  input  logic [1:0]                     cfgMode,
  input  logic                           unalignEn,
  input  logic                           reqValid,
  input  logic                           reqWrite,
  input  logic [1:0]                     reqSize,
  input  logic [$clog2(DATA_W/8)-1:0]    reqAddrLow,
  input  logic                           reqSigned,
  input  logic                           reqOvrValid,
  input  logic [1:0]                     reqOvrMode,
  input  logic                           rspValid,
  output ctrlStrobes_t                   strb,
  output logic                           busValid,
  output logic                           busWrite,
  output logic                           fault,
  output logic                           loadValid
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 2;

  logic [1:0]       baseMode;
  logic [1:0]       effModeRaw;
  endMode_e         effMode;
  accSize_e         sizeN;
  logic [CNT_W-1:0] nBytes;
  logic [CNT_W-1:0] span;
  logic             natMis;
  logic             crosses;
  logic             faultNow;
  logic             issue;
  logic             swapNow;
  logic [OFF_W-1:0] finOffs;

  logic             ldSwapQ;
  accSize_e         ldSizeQ;
  logic [OFF_W-1:0] ldOffsQ;
  logic             ldSignedQ;

  // Mode resolution, alignment check and sub-word remap
  always_comb begin
    baseMode   = strapLock ? strapMode : cfgMode;
    effModeRaw = reqOvrValid ? reqOvrMode : baseMode;
    effMode    = (effModeRaw == 2'd3) ? MODE_LE : endMode_e'(effModeRaw);
    sizeN      = (reqSize == 2'd3) ? SZ_WORD : accSize_e'(reqSize);
    case (sizeN)
      SZ_BYTE: nBytes = CNT_W'(1);
      SZ_HALF: nBytes = CNT_W'(2);
      default: nBytes = CNT_W'(LANES);
    endcase
    span     = CNT_W'(reqAddrLow) + nBytes;
    natMis   = ((CNT_W'(reqAddrLow)) & (nBytes - CNT_W'(1))) != '0;
    crosses  = span > CNT_W'(LANES);
    faultNow = (effMode == MODE_WI) ? natMis : (natMis && (!unalignEn || crosses));
    finOffs  = reqAddrLow;
    if (effMode == MODE_WI) begin
      if (sizeN == SZ_BYTE)      finOffs = reqAddrLow ^ OFF_W'(LANES - 1);
      else if (sizeN == SZ_HALF) finOffs = reqAddrLow ^ OFF_W'(LANES - 2);
    end
    swapNow = (effMode == MODE_BI) && (sizeN != SZ_BYTE);
    issue   = reqValid && !faultNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busValid  <= 1'b0;
      busWrite  <= 1'b0;
      fault     <= 1'b0;
      loadValid <= 1'b0;
      ldSwapQ   <= 1'b0;
      ldSizeQ   <= SZ_BYTE;
      ldOffsQ   <= '0;
      ldSignedQ <= 1'b0;
    end else begin
      busValid  <= issue;
      fault     <= reqValid && faultNow;
      loadValid <= rspValid;
      if (issue) busWrite <= reqWrite;
      if (issue && !reqWrite) begin
        ldSwapQ   <= swapNow;
        ldSizeQ   <= sizeN;
        ldOffsQ   <= finOffs;
        ldSignedQ <= reqSigned;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = issue;
    strb.capSwap  = swapNow;
    strb.capSize  = sizeN;
    strb.capOffs  = LANE_IDX_W'(finOffs);
    strb.ldTake   = rspValid;
    strb.ldSwap   = ldSwapQ;
    strb.ldSize   = ldSizeQ;
    strb.ldOffs   = LANE_IDX_W'(ldOffsQ);
    strb.ldSigned = ldSignedQ;
  end

endmodule

// File: rtl/elaDatapath.sv
module elaDatapath
  import elaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busBe,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   loadData
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0]  capOff;
  logic [OFF_W-1:0]  ldOff;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] wdNext;
  logic [DATA_W-1:0] ldNext;
  logic              signBit;

  assign capOff = strb.capOffs[OFF_W-1:0];
  assign ldOff  = strb.ldOffs[OFF_W-1:0];

  // Store side: place value bytes into lanes, reversed when asked
  always_comb begin
    int capN;
    int rel;
    int src;
    capN   = sizeBytes(strb.capSize, LANES);
    beNext = '0;
    wdNext = '0;
    for (int i = 0; i < LANES; i++) begin
      rel = i - int'(capOff);
      src = 0;
      if (rel >= 0 && rel < capN) begin
        beNext[i] = 1'b1;
        src = strb.capSwap ? (capN - 1 - rel) : rel;
        wdNext[i*8 +: 8] = reqWdata[src*8 +: 8];
      end
    end
  end

  // Load side: gather lanes down to bit 0, reorder, then extend
  always_comb begin
    int ldN;
    int src;
    ldN    = sizeBytes(strb.ldSize, LANES);
    ldNext = '0;
    for (int i = 0; i < LANES; i++) begin
      src = 0;
      if (i < ldN) begin
        src = (int'(ldOff) + (strb.ldSwap ? (ldN - 1 - i) : i)) % LANES;
        ldNext[i*8 +: 8] = rspRdata[src*8 +: 8];
      end
    end
    signBit = strb.ldSigned && ldNext[ldN*8 - 1];
    for (int i = 0; i < LANES; i++) begin
      if (i >= ldN) ldNext[i*8 +: 8] = {8{signBit}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busBe    <= '0;
      busWdata <= '0;
      loadData <= '0;
    end else begin
      if (strb.capture) begin
        busAddr  <= {reqAddr[ADDR_W-1:OFF_W], capOff};
        busBe    <= beNext;
        busWdata <= wdNext;
      end
      if (strb.ldTake) loadData <= ldNext;
    end
  end

endmodule

// File: rtl/endianLaneAdapter.sv
module endianLaneAdapter
  import elaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strapLock,
  input  logic [1:0]          strapMode,
  input  logic [1:0]          cfgMode,
  input  logic                unalignEn,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                reqSigned,
  input  logic                reqOvrValid,
  input  logic [1:0]          reqOvrMode,
  input  logic                rspValid,
  input  logic [DATA_W-1:0]   rspRdata,
  output logic                busValid,
  output logic                busWrite,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busBe,
  output logic [DATA_W-1:0]   busWdata,
  output logic                fault,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData
);

  localparam int OFF_W = $clog2(DATA_W / 8);

  ctrlStrobes_t strb;

  elaCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strapLock  (strapLock),
    .strapMode  (strapMode),
    .cfgMode    (cfgMode),
    .unalignEn  (unalignEn),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddrLow (reqAddr[OFF_W-1:0]),
    .reqSigned  (reqSigned),
    .reqOvrValid(reqOvrValid),
    .reqOvrMode (reqOvrMode),
    .rspValid   (rspValid),
    .strb       (strb),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .fault      (fault),
    .loadValid  (loadValid)
  );

  elaDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspRdata(rspRdata),
    .busAddr (busAddr),
    .busBe   (busBe),
    .busWdata(busWdata),
    .loadData(loadData)
  );

endmodule

// File: rtl/endianLaneAdapterChk.sv
module endianLaneAdapterChk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [1:0]          reqSize,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                reqOvrValid,
  input logic [1:0]          reqOvrMode,
  input logic                rspValid,
  input logic                busValid,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W/8-1:0] busBe,
  input logic                fault,
  input logic                loadValid
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  bus_or_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && fault));

  // R9
  beat_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && (busValid || fault)) |-> $past(reqValid));

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($countones(busBe) == 1 || $countones(busBe) == 2 || $countones(busBe) == LANES));

  // R3
  wi_byte_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && busValid && $past(reqOvrValid && reqOvrMode == 2'd2 && reqSize == 2'd0))
      |-> busAddr[OFF_W-1:0] == ($past(reqAddr[OFF_W-1:0]) ^ OFF_W'(LANES - 1)));

  // R4
  wi_odd_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(reqValid && reqOvrValid && reqOvrMode == 2'd2 && reqSize != 2'd0 && reqAddr[0]))
      |-> fault);

  // R6
  bi_addr_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && busValid && $past(reqOvrValid && reqOvrMode == 2'd1)) |-> busAddr == $past(reqAddr));

  // R10
  load_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && loadValid) |-> $past(rspValid));

  // R10
  rsp_gives_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> loadValid);

endmodule

bind endianLaneAdapter endianLaneAdapterChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_endianLaneAdapter.sv
module test_endianLaneAdapter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapLock = 1'b0;
  logic [1:0]  strapMode = 2'd0;
  logic [1:0]  cfgMode = 2'd0;
  logic        unalignEn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqSigned = 1'b0;
  logic        reqOvrValid = 1'b0;
  logic [1:0]  reqOvrMode = 2'd0;
  logic        rspValid = 1'b0;
  logic [31:0] rspRdata = '0;
  logic        busValid;
  logic        busWrite;
  logic [31:0] busAddr;
  logic [3:0]  busBe;
  logic [31:0] busWdata;
  logic        fault;
  logic        loadValid;
  logic [31:0] loadData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  endianLaneAdapter i_endianLaneAdapter (.*);

  // Behavioural reference state
  logic        eBusValid = 1'b0, eBusWrite = 1'b0, eFault = 1'b0, eLoadValid = 1'b0;
  logic [31:0] eBusAddr = '0, eBusWdata = '0, eLoadData = '0;
  logic [3:0]  eBusBe = '0;
  int          ctxOff = 0, ctxN = 1;
  bit          ctxSwap = 0, ctxSigned = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      eBusValid = 0; eFault = 0; eLoadValid = 0;
    end else begin
      int mode, n, off, fo;
      bit bad, swap;
      byte unsigned vb[4];
      mode = reqOvrValid ? int'(reqOvrMode) : (strapLock ? int'(strapMode) : int'(cfgMode));
      if (mode == 3) mode = 0;
      n = (reqSize == 0) ? 1 : (reqSize == 1) ? 2 : 4;
      off = int'(reqAddr[1:0]);
      if (mode == 2) bad = (off % n) != 0;
      else           bad = ((off % n) != 0) && (!unalignEn || (off + n > 4));
      swap = (mode == 1) && (n > 1);
      // load result from the response of this edge, using the old context
      eLoadValid = rspValid;
      if (rspValid) begin
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < ctxN; k++)
          vb[k] = rspRdata[(ctxOff + k) * 8 +: 8];
        for (int k = 0; k < ctxN; k++)
          v[k*8 +: 8] = ctxSwap ? vb[ctxN - 1 - k] : vb[k];
        if (ctxSigned && ctxN < 4 && v[ctxN*8 - 1])
          for (int b = ctxN * 8; b < 32; b++) v[b] = 1'b1;
        eLoadData = v;
      end
      eFault = reqValid && bad;
      eBusValid = reqValid && !bad;
      if (eBusValid) begin
        fo = off;
        if (mode == 2) fo = (n == 1) ? (off ^ 3) : (n == 2) ? (off ^ 2) : off;
        eBusWrite = reqWrite;
        eBusAddr = {reqAddr[31:2], 2'(fo)};
        eBusBe = '0;
        eBusWdata = '0;
        for (int k = 0; k < n; k++) begin
          eBusBe[fo + k] = 1'b1;
          eBusWdata[(fo + k) * 8 +: 8] = swap ? reqWdata[(n - 1 - k) * 8 +: 8] : reqWdata[k * 8 +: 8];
        end
        if (!reqWrite) begin
          ctxOff = fo; ctxN = n; ctxSwap = swap; ctxSigned = reqSigned;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R9", "busValid", 32'(busValid), 32'(eBusValid));
      check("R5", "fault", 32'(fault), 32'(eFault));
      check("R10", "loadValid", 32'(loadValid), 32'(eLoadValid));
      if (rstN && eBusValid) begin
        check("R3", "busAddr", busAddr, eBusAddr);
        check("R2", "busBe", 32'(busBe), 32'(eBusBe));
        check("R9", "busWrite", 32'(busWrite), 32'(eBusWrite));
        if (eBusWrite) check("R7", "busWdata", busWdata, eBusWdata);
      end
      if (rstN && eLoadValid) check("R8", "loadData", loadData, eLoadData);
    end
  end

  task automatic access(bit wr, int sz, logic [31:0] addr, logic [31:0] wd, bit sgn,
                        bit ovr, int ovrM, bit ua, logic [31:0] rd);
    reqValid = 1; reqWrite = wr; reqSize = 2'(sz); reqAddr = addr; reqWdata = wd;
    reqSigned = sgn; reqOvrValid = ovr; reqOvrMode = 2'(ovrM); unalignEn = ua;
    @(negedge clk);
    reqValid = 0;
    reqOvrValid = 0;
    if (!wr) begin rspValid = 1; rspRdata = rd; end
    @(negedge clk);
    rspValid = 0;
    rspRdata = ~rd;
    @(negedge clk);
  endtask

  initial begin
    int k;
    k = 0;
    // reset state is compared on every negedge during reset (R9, R10)
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: default source alternates between strap and register, override per access
    for (int cs = 0; cs < 4; cs++) begin
      strapLock = cs[0];
      strapMode = 2'(cs + 1);
      cfgMode   = 2'(cs);
      for (int ov = 0; ov < 2; ov++)
        for (int om = 0; om < 4; om++)
          for (int sz = 0; sz < 4; sz++)      // R2 sizes incl. code 11
            for (int of = 0; of < 4; of++)    // R4 R5 offsets
              for (int wr = 0; wr < 2; wr++)  // R6 R7 stores, R8 loads
                for (int sg = 0; sg < 2; sg++)
                  for (int ua = 0; ua < 2; ua++) begin
                    access(wr[0], sz, 32'h4000_1000 + 32'(k << 4) + 32'(of),
                           32'hA1B2_C3D4 + 32'(k) * 32'h0103_0507, sg[0], ov[0], om, ua[0],
                           32'h8F7E_E1C2 ^ (32'(k) * 32'h0011_2233));
                    k++;
                  end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule